// File: doc/BRIEF.md
# Seconds Counter with Alarm on an APB Register Bus

This block is a real-time clock peripheral on an APB register bus. A free-running prescaler divides the system clock down to one pulse per second. Each pulse advances a 32-bit seconds count, which wraps modulo 2^32. Software can overwrite the count at any time, and can program an alarm value. The alarm raises a sticky raw flag when the count becomes equal to it. A one-bit enable gates the raw flag onto the interrupt pin. Writing the acknowledge register drops the flag.

The alarm comparison is made against the values that the registers will hold after the current edge. A write to the alarm register or to the count register that makes the two equal therefore raises the flag on that same edge. The block does not wait for the next second. The 4 KB window also holds fixed identification bytes, one byte per word, near its top. Every transfer completes with no wait states.

Top module: `rtc_apb`

## Requirements
- R1: After reset, the count, alarm, last-loaded value, enable bit and raw flag are all zero. `irq` is low, `pready` is 1 and `pslverr` is 0.
- R2: The count rises by exactly 1 once every CLK_HZ clock cycles. A write to the load register restarts the prescaler, so the first increment after a load comes CLK_HZ cycles after the write edge.
- R3: A write to the load register (offset 0x08) sets the count to the written value. Reads of offset 0x00 return the count. Offset 0x08 and the alarm register (offset 0x04) read back the last value written to them.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000.
- R5: When the count advances to equal the alarm value, the raw flag is set on that same edge.
- R6: If a write to the load register or to the alarm register leaves the count equal to the alarm value, the raw flag is set on that write edge.
- R7: The enable register (offset 0x10) keeps only bit 0. `irq` is the raw flag AND the enable bit. Offset 0x14 reads the raw flag in bit 0. Offset 0x18 reads raw AND enable in bit 0.
- R8: A write of any value to offset 0x1C clears the raw flag, including a value whose bit 0 is 0.
- R9: Offset 0x0C always reads 1, and writes to it change nothing.
- R10: Word offsets 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R11: Reads of offset 0x1C, of unmapped offsets and of misaligned addresses return 0. Writes to offsets 0x00, 0x14 and 0x18, and to unmapped offsets, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | System clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Alarm interrupt, raw flag AND enable |

## Verification
A fault in the prescaler shows up as a count that moves in the wrong cycle. To catch it, the bench reads the count at four points, spaced three cycles apart, after a load. Any period other than CLK_HZ gives a different sequence of values. A wrong compare or a wrong flag update shows on `irq` at one exact edge. The bench checks the pin half a cycle before and half a cycle after the edge on which the count reaches the alarm value, and just after load, alarm and acknowledge writes. A wrongly stored register shows on the next read of its offset, at most three cycles later.

// File: rtl/rtc_apb.sv
module rtc_apb #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        irq
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(CLK_HZ - 1);

  localparam logic [9:0] W_CNT = 10'h000, W_ALM = 10'h001, W_LD  = 10'h002,
                         W_CTL = 10'h003, W_EN  = 10'h004, W_RAW = 10'h005,
                         W_MSK = 10'h006, W_ACK = 10'h007;

  logic [PW-1:0] pre;
  logic [31:0]   cnt, alm, ld;
  logic          en, raw;

  wire [9:0] word  = paddr[11:2];
  wire       align = (paddr[1:0] == 2'b00);
  wire       wr    = psel & penable & pwrite & align;
  wire       tick  = (pre == PRE_TOP);
  wire       ld_wr  = wr && (word == W_LD);
  wire       alm_wr = wr && (word == W_ALM);
  wire       en_wr  = wr && (word == W_EN);
  wire       ack_wr = wr && (word == W_ACK);

  wire [31:0] cnt_nx = ld_wr  ? pwdata : (tick ? cnt + 32'd1 : cnt);
  wire [31:0] alm_nx = alm_wr ? pwdata : alm;
  wire        hit    = (ld_wr | alm_wr | tick) && (cnt_nx == alm_nx);

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      pre <= '0;
      cnt <= '0;
      alm <= '0;
      ld  <= '0;
      en  <= 1'b0;
      raw <= 1'b0;
    end else begin
      pre <= (ld_wr || tick) ? '0 : pre + 1'b1;
      cnt <= cnt_nx;
      alm <= alm_nx;
      if (ld_wr) ld <= pwdata;
      if (en_wr) en <= pwdata[0];
      if (hit)         raw <= 1'b1;
      else if (ack_wr) raw <= 1'b0;
    end
  end

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  always_comb begin
    prdata = '0;
    if (align) begin
      if (word[9:3] == 7'h7F) prdata = {24'h0, id_byte(word[2:0])};
      else case (word)
        W_CNT:   prdata = cnt;
        W_ALM:   prdata = alm;
        W_LD:    prdata = ld;
        W_CTL:   prdata = 32'd1;
        W_EN:    prdata = {31'd0, en};
        W_RAW:   prdata = {31'd0, raw};
        W_MSK:   prdata = {31'd0, raw & en};
        default: prdata = '0;
      endcase
    end
  end

  assign irq     = raw & en;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  AST_TICK_STEP: assert property (@(posedge pclk) disable iff (!presetn)
    (tick && !ld_wr) |=> (cnt == $past(cnt) + 32'd1)); // R2
  AST_LOAD_TAKES: assert property (@(posedge pclk) disable iff (!presetn)
    ld_wr |=> (cnt == $past(pwdata))); // R3
  AST_RAISE_AT_MATCH: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(raw) |-> (cnt == alm)); // R5
  AST_ACK_DROPS: assert property (@(posedge pclk) disable iff (!presetn)
    ack_wr |=> (!raw || cnt == alm)); // R8
  AST_CTL_ONE: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && align && word == W_CTL) |-> (prdata == 32'd1)); // R9
endmodule

// File: tb/rtc_apb_tb.sv
module rtc_apb_tb_top;
  localparam int unsigned HZ = 4;
  localparam int NV = 20;

  logic clk = 1'b0, rstn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rtc_apb #(.CLK_HZ(HZ)) dut_i (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq));

  // {write, addr, data, expected read}
  localparam logic [76:0] TBL [NV] = '{
    {1'b1, 12'h004, 32'hDEADBEEF, 32'h0},        // R3
    {1'b0, 12'h004, 32'h0, 32'hDEADBEEF},        // R3
    {1'b1, 12'h00C, 32'h0, 32'h0},               // R9
    {1'b0, 12'h00C, 32'h0, 32'h1},               // R9
    {1'b1, 12'h010, 32'hFFFFFFFF, 32'h0},        // R7
    {1'b0, 12'h010, 32'h0, 32'h1},               // R7
    {1'b1, 12'h010, 32'h0, 32'h0},               // R7
    {1'b0, 12'h010, 32'h0, 32'h0},               // R7
    {1'b0, 12'hFE0, 32'h0, 32'h31},              // R10
    {1'b0, 12'hFE4, 32'h0, 32'h10},
    {1'b0, 12'hFE8, 32'h0, 32'h14},
    {1'b0, 12'hFEC, 32'h0, 32'h00},
    {1'b0, 12'hFF0, 32'h0, 32'h0D},
    {1'b0, 12'hFF4, 32'h0, 32'hF0},
    {1'b0, 12'hFF8, 32'h0, 32'h05},
    {1'b0, 12'hFFC, 32'h0, 32'hB1},
    {1'b0, 12'h01C, 32'h0, 32'h0},               // R11
    {1'b0, 12'h020, 32'h0, 32'h0},               // R11
    {1'b1, 12'h800, 32'h12345678, 32'h0},        // R11
    {1'b0, 12'h005, 32'h0, 32'h0}                // R11 misaligned
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstn = 1;
    apb_rd(12'h000, r); check("R1 count", r, 0);
    apb_rd(12'h004, r); check("R1 alarm", r, 0);
    apb_rd(12'h008, r); check("R1 load", r, 0);
    apb_rd(12'h014, r); check("R1 raw", r, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][76]) apb_wr(TBL[i][75:64], TBL[i][63:32]);
      else begin
        apb_rd(TBL[i][75:64], r);
        check($sformatf("R3/R7/R9/R10/R11 vec%0d", i), r, TBL[i][31:0]);
      end
    end

    apb_wr(12'h008, 32'h1000);
    apb_rd(12'h000, r); check("R3 load value", r, 32'h1000);
    apb_rd(12'h000, r); check("R2 first step", r, 32'h1001);
    apb_rd(12'h000, r); check("R2 hold", r, 32'h1002);
    apb_rd(12'h000, r); check("R2 period", r, 32'h1002);
    apb_rd(12'h008, r); check("R3 load readback", r, 32'h1000);

    apb_wr(12'h008, 32'hFFFFFFFF);
    apb_rd(12'h000, r); check("R4 before wrap", r, 32'hFFFFFFFF);
    apb_rd(12'h000, r); check("R4 wrapped", r, 32'h0);

    apb_wr(12'h010, 32'h1);
    apb_wr(12'h004, 32'h200);
    apb_wr(12'h008, 32'h1FE);
    repeat (7) @(negedge clk);
    check("R5 not yet", {31'd0, irq}, 0);
    @(negedge clk);
    check("R5 raised", {31'd0, irq}, 1);

    apb_wr(12'h01C, 32'h2);
    check("R8 ack any value", {31'd0, irq}, 0);
    apb_wr(12'h004, 32'h100);
    apb_wr(12'h008, 32'h100);
    check("R6 load hits", {31'd0, irq}, 1);
    apb_wr(12'h01C, 32'h0);
    apb_rd(12'h014, r); check("R8 raw cleared", r, 0);

    apb_wr(12'h008, 32'h50);
    apb_wr(12'h004, 32'h50);
    check("R6 alarm write hits", {31'd0, irq}, 1);
    apb_wr(12'h010, 32'h0);
    check("R7 masked irq", {31'd0, irq}, 0);
    apb_rd(12'h018, r); check("R7 masked status", r, 0);
    apb_rd(12'h014, r); check("R7 raw kept", r, 1);
    apb_wr(12'h01C, 32'hFFFFFFFE);
    apb_wr(12'h014, 32'h1);
    apb_wr(12'h018, 32'h1);
    apb_rd(12'h014, r); check("R11 raw write ignored", r, 0);

    apb_wr(12'h008, 32'h777);
    apb_wr(12'h000, 32'h0);
    apb_rd(12'h000, r); check("R11 count write ignored", r, 32'h778);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule